// File: doc/BRIEF.md
# Multi-error ECC correction sequencer

This block runs the correction phase of a sector ECC engine that can repair up to four byte errors in a 512-byte sector. It does none of the syndrome arithmetic. It drives the engine's register port through the fixed sequence the engine expects, then applies each reported fix to a sector buffer through a byte-wide read/write port.

On a request, the block loads the eight expected 10-bit check values and reads a status word so the syndrome has time to settle. It then tests the four syndrome words. A clean sector ends the request at once. Otherwise the block clears any stale location result and starts the location calculation. Next it waits on the engine's 4-bit state field, taking care not to trust the state from just after the start. Finally it reads back up to four address/value pairs and XOR-patches the buffer.

The result is a count of the fixes applied, or an uncorrectable flag. It is returned through a busy/done handshake.

Top module: `ecs_fix_seq`

## Requirements
- R1: After a request, the block issues eight writes to register code 5. Each write carries a 10-bit expected check value, zero-extended. The order is index 7 first, down to index 0; index i sits at bits 10*i+9:10*i of `check_codes`.
- R2: After the loads, the block reads status (code 0) once. It then reads syndrome codes 1, 2, 3 and 4 in that order. Only bits 25:16 and 9:0 of each syndrome word count. If all of them are zero, the request ends with count 0: no control write, no buffer access, and the last register read is code 4.
- R3: In any cycle, at most one of `reg_rd` and `reg_wr` is high.
- R4: A nonzero syndrome leads to a dummy read of code 7, then a write to control code 6 with bit 13 set.
- R5: After the start write, status is read every cycle. The state field (bits 11:8) is not trusted as final until it has read 4 or more, or until WAIT_LIMIT reads have been made.
- R6: While polling, state 0 ends with count 0 and state 1 ends with the uncorrectable flag and count 0. Both exits finish with a dummy read of code 9. Any state of 4 or more keeps polling.
- R7: States 2 and 3 give an error count equal to status bits 17:16 plus one. Errors 0 and 1 use address code 7 and value code 9. Errors 2 and 3 use address code 8 and value code 10. Odd errors take the upper 16-bit half. The address is bits 9:0 of the half and the value is bits 7:0.
- R8: The buffer index is 519 minus the address. A fix is applied only when that index is in 0..511, that is, for addresses 8 to 519. It is applied as a buffer read followed, the next cycle, by a write of the read byte XOR the value to the same index.
- R9: `fix_count` equals the number of fixes applied.
- R10: A request is accepted only while `busy` is low. `busy` stays high until a one-cycle `done` pulse. The results hold until the next accepted request, and a request made while busy is ignored.
- R11: Synchronous active-high reset leaves `busy`, `done`, the results and every strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Correction request |
| check_codes | input | 80 | Eight expected 10-bit check values, held stable while busy |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fix_count | output | 3 | Number of fixes applied |
| uncorrectable | output | 1 | Five or more errors reported |
| reg_rd | output | 1 | Engine register read strobe; data is taken in the same cycle |
| reg_wr | output | 1 | Engine register write strobe |
| reg_sel | output | 4 | Engine register code |
| reg_wdata | output | 32 | Engine register write data |
| reg_rdata | input | 32 | Engine register read data |
| buf_rd | output | 1 | Buffer byte read strobe; data returns next cycle |
| buf_wr | output | 1 | Buffer byte write strobe |
| buf_addr | output | 9 | Buffer byte index |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data |

## Verification
The assertions check the port discipline on every cycle. Read and write strobes never coincide. Each buffer write follows a read of the same index. `done` is a single pulse that closes a busy period, the count never exceeds four and is zero when the flag is set, and nothing moves while idle. The bench alone can show the sequence and ordering behaviour. That covers the reverse load order, the clean-sector shortcut, refusing an early "done" state, the wait timeout, and the pairing and halving of address registers. It also covers the 519-minus-address mapping at its edges and the buffer contents after patching, which it compares against expectations computed from an engine model.

// File: rtl/ecs_pkg.sv
package ecs_pkg;

    // Engine register codes
    localparam logic [3:0] RS_STATUS = 4'd0;
    localparam logic [3:0] RS_SYN0   = 4'd1;
    localparam logic [3:0] RS_LOAD   = 4'd5;
    localparam logic [3:0] RS_CTRL   = 4'd6;
    localparam logic [3:0] RS_EADDR0 = 4'd7;
    localparam logic [3:0] RS_EADDR1 = 4'd8;
    localparam logic [3:0] RS_EVAL0  = 4'd9;
    localparam logic [3:0] RS_EVAL1  = 4'd10;

    localparam int unsigned CALC_START_BIT = 13;
    localparam logic [31:0] PAIR_MASK      = 32'h03FF_03FF;

    typedef enum logic [3:0] {
        S_IDLE, S_LOAD, S_SETTLE, S_SYN, S_CLEAR, S_GO,
        S_WAIT4, S_POLL, S_EXIT, S_FETCH_A, S_FETCH_V,
        S_BUF_RD, S_BUF_WR, S_DONE
    } seq_state_e;

    typedef struct packed {
        logic [2:0] count;
        logic       uncorr;
    } result_t;

    function automatic logic pair_nonzero(input logic [31:0] w);
        return |(w & PAIR_MASK);
    endfunction

    function automatic logic [3:0] stat_state(input logic [31:0] w);
        return w[11:8];
    endfunction

    function automatic logic [2:0] stat_nerr(input logic [31:0] w);
        return {1'b0, w[17:16]} + 3'd1;
    endfunction

endpackage

// File: rtl/ecs_err_pick.sv
module ecs_err_pick #(
    parameter int DATA_BYTES = 512,
    parameter int CODE_W     = 10,
    parameter int AW         = 9
) (
    input  logic [31:0]   word,
    input  logic          upper,
    output logic [AW-1:0] idx,
    output logic          hit,
    output logic [7:0]    val
);
    localparam int OFS = DATA_BYTES + 7;

    logic [15:0]       half;
    logic [CODE_W-1:0] code;
    logic [CODE_W:0]   diff;

    always_comb begin
        half = upper ? word[31:16] : word[15:0];
        code = half[CODE_W-1:0];
        diff = (CODE_W+1)'(OFS) - {1'b0, code};
        hit  = ({1'b0, code} <= (CODE_W+1)'(OFS)) &&
               (diff < (CODE_W+1)'(DATA_BYTES));
        idx  = diff[AW-1:0];
        val  = half[7:0];
    end
endmodule

// File: rtl/ecs_wait_timer.sv
module ecs_wait_timer #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    assign expired = (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ecs_fix_seq.sv
module ecs_fix_seq
    import ecs_pkg::*;
#(
    parameter int DATA_BYTES = 512,
    parameter int CODE_W     = 10,
    parameter int N_CHECK    = 8,
    parameter int WAIT_LIMIT = 10000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [N_CHECK*CODE_W-1:0] check_codes,
    output logic                      busy,
    output logic                      done,
    output logic [2:0]                fix_count,
    output logic                      uncorrectable,
    output logic                      reg_rd,
    output logic                      reg_wr,
    output logic [3:0]                reg_sel,
    output logic [31:0]               reg_wdata,
    input  logic [31:0]               reg_rdata,
    output logic                      buf_rd,
    output logic                      buf_wr,
    output logic [$clog2(DATA_BYTES)-1:0] buf_addr,
    output logic [7:0]                buf_wdata,
    input  logic [7:0]                buf_rdata
);
    localparam int BUF_AW = $clog2(DATA_BYTES);
    localparam int KW     = $clog2(N_CHECK);

    seq_state_e      st;
    logic [KW-1:0]   k;
    logic [2:0]      nerr;
    logic            syn_nz;
    logic [BUF_AW-1:0] fix_idx;
    logic            fix_hit;
    logic [7:0]      fix_val;
    result_t         res;

    logic [BUF_AW-1:0] pick_idx;
    logic            pick_hit;
    logic [7:0]      pick_val;
    logic            tmr_exp;
    logic            last_err;
    logic [3:0]      rd_state;

    ecs_err_pick #(.DATA_BYTES(DATA_BYTES), .CODE_W(CODE_W), .AW(BUF_AW)) u_pick (
        .word(reg_rdata), .upper(k[0]), .idx(pick_idx), .hit(pick_hit), .val(pick_val)
    );

    ecs_wait_timer #(.LIMIT(WAIT_LIMIT)) u_tmr (
        .clk(clk), .rst(rst), .run(st == S_WAIT4), .expired(tmr_exp)
    );

    assign busy          = (st != S_IDLE);
    assign done          = (st == S_DONE);
    assign fix_count     = res.count;
    assign uncorrectable = res.uncorr;
    assign last_err      = ({{(3-KW > 0 ? 3-KW : 0){1'b0}}, k} == 3'(nerr - 3'd1));
    assign rd_state      = stat_state(reg_rdata);
    assign buf_addr      = fix_idx;
    assign buf_wdata     = buf_rdata ^ fix_val;

    // Register and buffer strobes decoded from the sequence state
    always_comb begin
        reg_rd    = 1'b0;
        reg_wr    = 1'b0;
        reg_sel   = RS_STATUS;
        reg_wdata = '0;
        buf_rd    = 1'b0;
        buf_wr    = 1'b0;
        unique case (st)
            S_LOAD: begin
                reg_wr    = 1'b1;
                reg_sel   = RS_LOAD;
                reg_wdata = 32'(check_codes[k*CODE_W +: CODE_W]);
            end
            S_SETTLE, S_WAIT4, S_POLL: reg_rd = 1'b1;
            S_SYN: begin
                reg_rd  = 1'b1;
                reg_sel = RS_SYN0 + 4'(k);
            end
            S_CLEAR: begin
                reg_rd  = 1'b1;
                reg_sel = RS_EADDR0;
            end
            S_GO: begin
                reg_wr    = 1'b1;
                reg_sel   = RS_CTRL;
                reg_wdata = 32'(1) << CALC_START_BIT;
            end
            S_EXIT: begin
                reg_rd  = 1'b1;
                reg_sel = RS_EVAL0;
            end
            S_FETCH_A: begin
                reg_rd  = 1'b1;
                reg_sel = k[1] ? RS_EADDR1 : RS_EADDR0;
            end
            S_FETCH_V: begin
                reg_rd  = 1'b1;
                reg_sel = k[1] ? RS_EVAL1 : RS_EVAL0;
            end
            S_BUF_RD: buf_rd = 1'b1;
            S_BUF_WR: buf_wr = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            k       <= '0;
            nerr    <= '0;
            syn_nz  <= 1'b0;
            fix_idx <= '0;
            fix_hit <= 1'b0;
            fix_val <= '0;
            res     <= '0;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    st  <= S_LOAD;
                    k   <= KW'(N_CHECK - 1);
                    res <= '0;
                end
                S_LOAD: begin
                    if (k == '0) st <= S_SETTLE;
                    else         k  <= k - 1'b1;
                end
                S_SETTLE: begin
                    st     <= S_SYN;
                    syn_nz <= 1'b0;
                end
                S_SYN: begin
                    if (k == KW'(3)) begin
                        k  <= '0;
                        st <= (syn_nz || pair_nonzero(reg_rdata)) ? S_CLEAR : S_DONE;
                    end else begin
                        k      <= k + 1'b1;
                        syn_nz <= syn_nz || pair_nonzero(reg_rdata);
                    end
                end
                S_CLEAR: st <= S_GO;
                S_GO:    st <= S_WAIT4;
                S_WAIT4: if (rd_state >= 4'd4 || tmr_exp) st <= S_POLL;
                S_POLL: begin
                    if (rd_state == 4'd0) begin
                        st <= S_EXIT;
                    end else if (rd_state == 4'd1) begin
                        st         <= S_EXIT;
                        res.uncorr <= 1'b1;
                    end else if (rd_state < 4'd4) begin
                        st   <= S_FETCH_A;
                        k    <= '0;
                        nerr <= stat_nerr(reg_rdata);
                    end
                end
                S_EXIT: st <= S_DONE;
                S_FETCH_A: begin
                    fix_idx <= pick_idx;
                    fix_hit <= pick_hit;
                    st      <= S_FETCH_V;
                end
                S_FETCH_V: begin
                    fix_val <= pick_val;
                    if (fix_hit)       st <= S_BUF_RD;
                    else if (last_err) st <= S_DONE;
                    else begin
                        k  <= k + 1'b1;
                        st <= S_FETCH_A;
                    end
                end
                S_BUF_RD: st <= S_BUF_WR;
                S_BUF_WR: begin
                    res.count <= res.count + 3'd1;
                    if (last_err) st <= S_DONE;
                    else begin
                        k  <= k + 1'b1;
                        st <= S_FETCH_A;
                    end
                end
                S_DONE:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ecs_fix_seq_chk.sv
module ecs_fix_seq_chk #(
    parameter int BUF_AW = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic [2:0]        fix_count,
    input logic              uncorrectable,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic              buf_rd,
    input logic              buf_wr,
    input logic [BUF_AW-1:0] buf_addr
);
    // R3: one register strobe at a time
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && reg_wr));

    // R8: each buffer write follows a read of the same byte
    a_r8_rmw_pair: assert property (@(posedge clk) disable iff (rst)
        buf_wr |-> ($past(buf_rd) && buf_addr == $past(buf_addr)));

    // R8: a buffer read is followed by the write
    a_r8_read_then_write: assert property (@(posedge clk) disable iff (rst)
        buf_rd |=> buf_wr);

    // R10: done is a single pulse inside a busy period
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_in_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    a_r10_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

    // R10: no activity while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(reg_rd || reg_wr || buf_rd || buf_wr));

    // R9: at most four fixes
    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        done |-> fix_count <= 3'd4);

    // R6: uncorrectable result carries no fixes
    a_r6_uncorr_zero: assert property (@(posedge clk) disable iff (rst)
        (done && uncorrectable) |-> fix_count == 3'd0);
endmodule

bind ecs_fix_seq ecs_fix_seq_chk #(.BUF_AW(BUF_AW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .fix_count(fix_count),
    .uncorrectable(uncorrectable), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .buf_rd(buf_rd), .buf_wr(buf_wr), .buf_addr(buf_addr)
);

// File: tb/ecs_fix_seq_tb.sv
module ecs_fix_seq_tb;
    localparam int LIM = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [79:0] check_codes;
    logic        busy, done, uncorrectable, reg_rd, reg_wr, buf_rd, buf_wr;
    logic [2:0]  fix_count;
    logic [3:0]  reg_sel;
    logic [31:0] reg_wdata, reg_rdata;
    logic [8:0]  buf_addr;
    logic [7:0]  buf_wdata, buf_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    ecs_fix_seq #(.WAIT_LIMIT(LIM)) u_dut (
        .clk(clk), .rst(rst), .start(start), .check_codes(check_codes),
        .busy(busy), .done(done), .fix_count(fix_count), .uncorrectable(uncorrectable),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .buf_rd(buf_rd), .buf_wr(buf_wr), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    // Engine model settings
    logic [31:0] m_syn;
    int          m_spur_n, m_busy_n;
    logic [3:0]  m_spur_state, m_final;
    logic [1:0]  m_field;
    logic [31:0] m_ea0, m_ea1, m_ev0, m_ev1;

    // Model state and logs
    int          st_n;
    logic        started;
    int          load_n, ctrl_n, done_n;
    logic [31:0] load_log [8];
    logic [31:0] ctrl_val;
    logic [3:0]  last_rd, rd_before_ctrl, prev_rd;
    logic [7:0]  mem [512];
    logic [7:0]  exp_mem [512];

    always_comb begin
        reg_rdata = 32'h0;
        if (reg_rd) begin
            case (reg_sel)
                4'd0: begin
                    if (!started)
                        reg_rdata = 32'h0;
                    else if (st_n < m_spur_n)
                        reg_rdata = {20'h0, m_spur_state, 8'h0};
                    else if (st_n < m_spur_n + m_busy_n)
                        reg_rdata = {14'h0, m_field, 4'h0, 4'h6, 8'h0};
                    else
                        reg_rdata = {14'h0, m_field, 4'h0, m_final, 8'h0};
                end
                4'd1, 4'd2, 4'd3, 4'd4: reg_rdata = (reg_sel == 4'd3) ? m_syn : 32'hFC00_FC00;
                4'd7:  reg_rdata = m_ea0;
                4'd8:  reg_rdata = m_ea1;
                4'd9:  reg_rdata = m_ev0;
                4'd10: reg_rdata = m_ev1;
                default: reg_rdata = 32'h0;
            endcase
        end
    end

    always @(posedge clk) begin
        if (buf_rd) buf_rdata <= mem[buf_addr];
        if (buf_wr) mem[buf_addr] <= buf_wdata;
    end

    always @(posedge clk) begin
        if (start && !busy) begin
            started <= 1'b0;
            st_n    <= 0;
            load_n  <= 0;
            ctrl_n  <= 0;
            done_n  <= 0;
            last_rd <= 4'hF;
            prev_rd <= 4'hF;
            rd_before_ctrl <= 4'hF;
        end else begin
            if (done) done_n <= done_n + 1;
            if (reg_wr && reg_sel == 4'd5) begin
                if (load_n < 8) load_log[load_n] <= reg_wdata;
                load_n <= load_n + 1;
            end
            if (reg_wr && reg_sel == 4'd6) begin
                ctrl_n <= ctrl_n + 1;
                ctrl_val <= reg_wdata;
                rd_before_ctrl <= prev_rd;
                started <= 1'b1;
                st_n <= 0;
            end
            if (reg_rd) begin
                last_rd <= reg_sel;
                prev_rd <= reg_sel;
                if (reg_sel == 4'd0 && started) st_n <= st_n + 1;
            end
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // nerr: number of errors the model reports (0 = no correction path)
    task automatic run(input string name, input logic [31:0] syn,
                       input int spur_n, input logic [3:0] spur_state, input int busy_n,
                       input logic [3:0] fin, input logic [1:0] field,
                       input logic [31:0] ea0, input logic [31:0] ea1,
                       input logic [31:0] ev0, input logic [31:0] ev1,
                       input int nerr, input logic exp_unc, input int exp_last,
                       input int exp_stn, input logic extra_start);
        int exp_cnt = 0;
        int guard = 0;
        int bad = 0;
        m_syn = syn; m_spur_n = spur_n; m_spur_state = spur_state; m_busy_n = busy_n;
        m_final = fin; m_field = field;
        m_ea0 = ea0; m_ea1 = ea1; m_ev0 = ev0; m_ev1 = ev1;
        for (int i = 0; i < 8; i++) check_codes[i*10 +: 10] = 10'(i * 97 + 300 + n_tests);
        for (int i = 0; i < 512; i++) begin
            mem[i] = 8'(i * 13 + n_tests);
            exp_mem[i] = mem[i];
        end
        for (int e = 0; e < nerr; e++) begin
            logic [31:0] aw, vw;
            logic [15:0] ah, vh;
            int a;
            aw = (e < 2) ? ea0 : ea1;
            vw = (e < 2) ? ev0 : ev1;
            ah = e[0] ? aw[31:16] : aw[15:0];
            vh = e[0] ? vw[31:16] : vw[15:0];
            a = int'(ah[9:0]);
            if (a >= 8 && a <= 519) begin
                exp_mem[519 - a] = exp_mem[519 - a] ^ vh[7:0];
                exp_cnt++;
            end
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (extra_start) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (!done && guard < 2000) begin
            @(negedge clk); guard++;
        end
        check(guard < 2000, {name, " R10 done reached"}, guard, 0);
        check(fix_count == 3'(exp_cnt), {name, " R9 fix count"}, int'(fix_count), exp_cnt);
        check(uncorrectable == exp_unc, {name, " R6 uncorrectable"}, int'(uncorrectable), int'(exp_unc));
        check(load_n == 8, {name, " R1 load count"}, load_n, 8);
        for (int j = 0; j < 8; j++)
            check(load_log[j] == 32'(check_codes[(7-j)*10 +: 10]), {name, " R1 load order"},
                  int'(load_log[j]), int'(check_codes[(7-j)*10 +: 10]));
        if (syn == 32'h0) begin
            check(ctrl_n == 0, {name, " R2 no start on clean"}, ctrl_n, 0);
        end else begin
            check(ctrl_n == 1 && ctrl_val[13], {name, " R4 start bit 13"}, int'(ctrl_val), 32'h2000);
            check(rd_before_ctrl == 4'd7, {name, " R4 dummy address read"}, int'(rd_before_ctrl), 7);
        end
        if (exp_last >= 0)
            check(last_rd == 4'(exp_last), {name, " R2/R6 last read"}, int'(last_rd), exp_last);
        if (exp_stn >= 0)
            check(st_n == exp_stn, {name, " R5 status polls"}, st_n, exp_stn);
        repeat (6) @(negedge clk);
        check(done_n == 1, {name, " R10 single done"}, done_n, 1);
        check(!busy && fix_count == 3'(exp_cnt), {name, " R10 result holds"}, int'(fix_count), exp_cnt);
        for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) bad++;
        check(bad == 0, {name, " R8 buffer contents"}, bad, 0);
    endtask

    initial begin
        check_codes = '0;
        m_syn = 0; m_spur_n = 0; m_busy_n = 0; m_spur_state = 0; m_final = 0; m_field = 0;
        m_ea0 = 0; m_ea1 = 0; m_ev0 = 0; m_ev1 = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done, "R11 reset busy/done", int'(busy), 0);
        check(fix_count == 0 && !uncorrectable, "R11 reset results", int'(fix_count), 0);
        check(!reg_rd && !reg_wr && !buf_rd && !buf_wr, "R11 reset strobes", int'(reg_rd), 0);

        // R2: clean sector (only masked-out syndrome bits set elsewhere)
        run("clean", 32'h0, 0, 4'd0, 1, 4'd2, 2'd0, 0, 0, 0, 0, 0, 1'b0, 4, -1, 1'b0);
        // R7/R8: single error
        run("single", 32'h0000_0001, 0, 4'd0, 1, 4'd2, 2'd0,
            32'h0000_0064, 0, 32'h0000_5AC3, 0, 1, 1'b0, -1, -1, 1'b0);
        // R8: boundary addresses 519, 8, 7, 520 over both register pairs
        run("bounds", 32'h0001_0000, 0, 4'd0, 1, 4'd3, 2'd3,
            {16'd8, 16'd519}, {16'd520, 16'd7}, 32'h11A5_205A, 32'h0F0F_F0F0,
            4, 1'b0, -1, -1, 1'b0);
        // R7: sweep of error counts and address patterns
        for (int f = 0; f < 4; f++) begin
            logic [15:0] a0, a1, a2, a3;
            a0 = 16'((37 * f + 11) % 600); a1 = 16'((91 * f + 250) % 600);
            a2 = 16'((53 * f + 500) % 600); a3 = 16'((17 * f + 5) % 600);
            run("sweep", 32'h0200_0000, 0, 4'd0, 2, 4'd2, 2'(f),
                {a1, a0}, {a3, a2}, {8'h00, 8'(f + 3), 8'h00, 8'h81},
                {8'h00, 8'h3C, 8'h00, 8'(8'h40 + f)}, f + 1, 1'b0, -1, -1, 1'b0);
        end
        // R6: uncorrectable exit with dummy value read
        run("uncorr", 32'h0000_0300, 0, 4'd0, 1, 4'd1, 2'd2,
            32'h0000_0064, 0, 32'h0000_00FF, 0, 0, 1'b1, 9, -1, 1'b0);
        // R6: no-error exit
        run("noerr", 32'h0000_0300, 0, 4'd0, 1, 4'd0, 2'd0,
            32'h0000_0064, 0, 32'h0000_00FF, 0, 0, 1'b0, 9, -1, 1'b0);
        // R5: early state 3 must not be trusted; real report has four errors
        run("spurious", 32'h0000_0001, 3, 4'd3, 2, 4'd2, 2'd3,
            {16'd300, 16'd200}, {16'd100, 16'd50}, 32'h0202_0101, 32'h0808_0404,
            4, 1'b0, -1, 6, 1'b0);
        // R5: state never reaches 4, timeout then trust state 2 with one error
        run("timeout", 32'h0000_0001, 100000, 4'd2, 0, 4'd2, 2'd0,
            32'h0000_0190, 0, 32'h0000_0077, 0, 1, 1'b0, -1, LIM + 1, 1'b0);
        // R10: a request while busy is ignored
        run("busy_start", 32'h0000_0001, 0, 4'd0, 1, 4'd2, 2'd1,
            {16'd20, 16'd30}, 0, 32'h0055_0066, 0, 2, 1'b0, -1, -1, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R10: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule